// File: doc/BRIEF.md
# Pin Bank Controller with Interrupts

A parameterised bank of general-purpose pins behind an APB slave port, with one bit per pin in every register. Software reads pin levels through a two-stage synchronizer and changes output levels atomically. It writes ones to a set word or a clear word, so it never needs a read-modify-write. Direction is changed the same way through a pair of words. A loopback switch routes the output register back into the input path in place of the pins. This lets software test the bank with no external wiring.

Each pin has its own interrupt cell. The cell has an enable, a choice of level or edge sensitivity, and a polarity. An any-edge override makes an edge-mode pin fire on both transitions, whatever its polarity. Edge events stay latched until software writes a one to the flag-clear word. Level events follow the synchronized pin and are never latched. A single interrupt output is the OR of every enabled status bit.

The bus side runs a three-state machine. IDLE moves to SETUP when `psel` is high and `penable` is low. SETUP moves to ACCESS when `psel` and `penable` are both high, and otherwise falls back to IDLE. ACCESS returns to SETUP when a new setup phase follows at once, and otherwise returns to IDLE. Read data is captured on the setup edge. A write is committed only on the SETUP-to-ACCESS transition.

Top module: `gpio_apb_irq`

## Requirements
- R1: After reset, all output, direction, enable, mode, polarity, any-edge and loopback bits are zero. `pin_oe` and `pin_out` are zero, `irq` is low and `pready` is high.
- R2: The word index is `paddr[5:2]`. Reading index 0 returns the pin inputs through a two-flop synchronizer. Writing index 0 sets the `pin_out` bits written as one and leaves the other bits unchanged.
- R3: Writing index 1 clears the `pin_out` bits written as one and leaves the other bits unchanged.
- R4: Writing ones to index 2 makes those pins outputs (`pin_oe` high). Writing ones to index 3 makes them inputs. Zero bits leave the direction unchanged. Both indices read back the direction mask.
- R5: Ones written to index 4 set interrupt enables, and ones written to index 5 clear them. Both indices read back the enable mask. `irq` is the OR of (status AND enable), so it stays low while the mask is zero.
- R6: Ones written to index 6 make pins edge-sensitive, and ones written to index 7 make them level-sensitive. Both indices read back the mode mask, where 1 means edge.
- R7: A level-mode pin's status equals the synchronized input when polarity is 1. It equals the inverse of that input when polarity is 0. The status is not latched.
- R8: Ones written to index 8 set polarity to 1, and ones written to index 9 set it to 0. Both indices read back the polarity mask. An edge-mode pin latches its flag on a rising edge (polarity 1) or a falling edge (polarity 0).
- R9: Ones written to index 10 set the any-edge bit, and ones written to index 11 clear it. Both indices read back the any-edge mask. With the bit set, an edge-mode pin latches on both transitions.
- R10: Writing ones to index 12 clears the latched edge flags for those pins. A new edge in the same cycle wins over the clear. Reading index 12 returns zero.
- R11: Bit 0 of index 13 enables loopback, in which `pin_out` replaces `pin_in` at the synchronizer input. Index 13 reads back that bit.
- R12: Reading index 1 returns the per-pin status, whatever the enable mask holds.
- R13: Indices 14 and 15, addresses with nonzero bits above bit 5, and addresses with nonzero bits 1:0 all read zero and ignore writes.
- R14: A write is committed only when an access phase directly follows a setup phase. An access phase on its own changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, captured in the setup phase |
| pready | output | 1 | Always high, so no wait states |
| pin_in | input | N_PINS (32) | Pin levels from the pads |
| pin_out | output | N_PINS (32) | Output register |
| pin_oe | output | N_PINS (32) | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted output or direction bit shows on `pin_out` or `pin_oe` at the next falling clock after the write commits. A synchronizer or loopback fault shows as a wrong readback of index 0 a few cycles after the pins change. A wrong edge flag or enable bit shows on `irq` within four cycles of a pin transition. The same fault also shows in the status word at index 1. A flag that fails to clear keeps `irq` high one cycle after the clear write. A machine that commits outside a proper setup/access pair shows as a changed `pin_out` after a lone access phase.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } apb_state_e;

    localparam logic [3:0] IDX_IN_SET    = 4'd0;
    localparam logic [3:0] IDX_STAT_CLR  = 4'd1;
    localparam logic [3:0] IDX_DIR_OUT   = 4'd2;
    localparam logic [3:0] IDX_DIR_IN    = 4'd3;
    localparam logic [3:0] IDX_IEN_SET   = 4'd4;
    localparam logic [3:0] IDX_IEN_CLR   = 4'd5;
    localparam logic [3:0] IDX_EDGE      = 4'd6;
    localparam logic [3:0] IDX_LEVEL     = 4'd7;
    localparam logic [3:0] IDX_POL_HI    = 4'd8;
    localparam logic [3:0] IDX_POL_LO    = 4'd9;
    localparam logic [3:0] IDX_ANY_SET   = 4'd10;
    localparam logic [3:0] IDX_ANY_CLR   = 4'd11;
    localparam logic [3:0] IDX_FLAG_CLR  = 4'd12;
    localparam logic [3:0] IDX_CTRL      = 4'd13;

endpackage

// File: rtl/gpio_apb_fsm.sv
module gpio_apb_fsm
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic setup_hit,
    output logic access_hit
);

    apb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        setup_hit  = 1'b0;
        access_hit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (psel && !penable) begin
                    state_d   = ST_SETUP;
                    setup_hit = 1'b1;
                end
            end
            ST_SETUP: begin
                if (psel && penable) begin
                    state_d    = ST_ACCESS;
                    access_hit = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_ACCESS: begin
                if (psel && !penable) begin
                    state_d   = ST_SETUP;
                    setup_hit = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_access_needs_setup_R14: assert property (@(posedge clk) disable iff (!rst_n)
        access_hit |-> $past(setup_hit));

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] loop_src,
    input  logic             loop_en,
    output logic [WIDTH-1:0] s_now,
    output logic [WIDTH-1:0] s_prev
);

    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] meta_q;
    logic             live_q;

    assign src = loop_en ? loop_src : pin_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            s_now  <= '0;
            s_prev <= '0;
            live_q <= 1'b0;
        end else begin
            meta_q <= src;
            s_now  <= meta_q;
            s_prev <= s_now;
            live_q <= 1'b1;
        end
    end

    assert_first_stage_R2: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        meta_q == $past(src));

    assert_history_R2: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        s_prev == $past(s_now));

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic s_now,
    input  logic s_prev,
    input  logic edge_mode,
    input  logic pol_high,
    input  logic any_edge,
    input  logic flag_clr,
    output logic status
);

    logic rise, fall, trig, flag_q;

    assign rise = s_now & ~s_prev;
    assign fall = ~s_now & s_prev;
    assign trig = any_edge ? (rise | fall) : (pol_high ? rise : fall);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (!edge_mode) flag_q <= 1'b0;
        else if (trig)       flag_q <= 1'b1;
        else if (flag_clr)   flag_q <= 1'b0;
    end

    assign status = edge_mode ? flag_q : (pol_high ? s_now : ~s_now);

    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && status && !flag_clr) |=> (status || !edge_mode));

    assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && flag_clr && !trig) |=> (!status || !edge_mode));

    assert_any_catches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && any_edge && (s_now != s_prev)) |=> (status || !edge_mode));

endmodule

// File: rtl/gpio_apb_irq.sv
module gpio_apb_irq
    import gpio_pkg::*;
#(
    parameter int unsigned N_PINS = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);

    localparam int unsigned IDX_LSB = 2;
    localparam int unsigned IDX_MSB = 5;

    logic              setup_hit, access_hit;
    logic [3:0]        widx;
    logic              addr_ok;
    logic              wr_hit;
    logic [N_PINS-1:0] wd;
    logic [N_PINS-1:0] out_q, dir_q, ien_q, edge_q, pol_q, any_q;
    logic              loop_q;
    logic [N_PINS-1:0] s_now, s_prev, status, flag_clr;
    logic [31:0]       rd_word;

    gpio_apb_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .setup_hit  (setup_hit),
        .access_hit (access_hit)
    );

    assign widx    = paddr[IDX_MSB:IDX_LSB];
    assign addr_ok = (paddr[ADDR_W-1:IDX_MSB+1] == '0) && (paddr[IDX_LSB-1:0] == '0);
    assign wr_hit  = access_hit && pwrite && addr_ok;
    assign wd      = pwdata[N_PINS-1:0];
    assign pready  = 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            ien_q  <= '0;
            edge_q <= '0;
            pol_q  <= '0;
            any_q  <= '0;
            loop_q <= 1'b0;
        end else if (wr_hit) begin
            case (widx)
                IDX_IN_SET:   out_q  <= out_q | wd;
                IDX_STAT_CLR: out_q  <= out_q & ~wd;
                IDX_DIR_OUT:  dir_q  <= dir_q | wd;
                IDX_DIR_IN:   dir_q  <= dir_q & ~wd;
                IDX_IEN_SET:  ien_q  <= ien_q | wd;
                IDX_IEN_CLR:  ien_q  <= ien_q & ~wd;
                IDX_EDGE:     edge_q <= edge_q | wd;
                IDX_LEVEL:    edge_q <= edge_q & ~wd;
                IDX_POL_HI:   pol_q  <= pol_q | wd;
                IDX_POL_LO:   pol_q  <= pol_q & ~wd;
                IDX_ANY_SET:  any_q  <= any_q | wd;
                IDX_ANY_CLR:  any_q  <= any_q & ~wd;
                IDX_CTRL:     loop_q <= pwdata[0];
                default: ;
            endcase
        end
    end

    assign flag_clr = (wr_hit && widx == IDX_FLAG_CLR) ? wd : '0;

    gpio_sync #(.WIDTH(N_PINS)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .loop_src (out_q),
        .loop_en  (loop_q),
        .s_now    (s_now),
        .s_prev   (s_prev)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_cell
        gpio_irq_cell i_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .s_now     (s_now[g]),
            .s_prev    (s_prev[g]),
            .edge_mode (edge_q[g]),
            .pol_high  (pol_q[g]),
            .any_edge  (any_q[g]),
            .flag_clr  (flag_clr[g]),
            .status    (status[g])
        );
    end

    always_comb begin
        rd_word = '0;
        if (addr_ok) begin
            case (widx)
                IDX_IN_SET:               rd_word[N_PINS-1:0] = s_now;
                IDX_STAT_CLR:             rd_word[N_PINS-1:0] = status;
                IDX_DIR_OUT, IDX_DIR_IN:  rd_word[N_PINS-1:0] = dir_q;
                IDX_IEN_SET, IDX_IEN_CLR: rd_word[N_PINS-1:0] = ien_q;
                IDX_EDGE, IDX_LEVEL:      rd_word[N_PINS-1:0] = edge_q;
                IDX_POL_HI, IDX_POL_LO:   rd_word[N_PINS-1:0] = pol_q;
                IDX_ANY_SET, IDX_ANY_CLR: rd_word[N_PINS-1:0] = any_q;
                IDX_CTRL:                 rd_word[0] = loop_q;
                default:                  rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         prdata <= '0;
        else if (setup_hit) prdata <= rd_word;
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |(status & ien_q);

    assert_out_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && widx == IDX_IN_SET) |=> ((pin_out & $past(wd)) == $past(wd)));

    assert_out_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && widx == IDX_STAT_CLR) |=> ((pin_out & $past(wd)) == '0));

    assert_dir_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && widx == IDX_DIR_OUT) |=> ((pin_oe & $past(wd)) == $past(wd)));

    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

endmodule

// File: tb/test_gpio_apb_irq.sv
module test_gpio_apb_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic        rd_strobe = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    gpio_apb_irq i_gpio_apb_irq (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rd_strobe) begin
            chk(tag_q.pop_front(), prdata, exp_q.pop_front());
            rd_strobe = 1'b0;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        @(posedge clk); #1 rd_strobe = 1'b1;
        @(negedge clk); psel = 0; penable = 0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [7:0] ad(input int idx);
        return 8'(idx * 4);
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 pin_oe", pin_oe, 32'd0);
        chk("R1 pin_out", pin_out, 32'd0);
        chk("R1 pready", {31'd0, pready}, 32'd1);
        rd(ad(2), 32'd0, "R1 dir");
        rd(ad(13), 32'd0, "R1 ctrl");

        pin_in = 32'h0000_00A5; settle();
        rd(ad(0), 32'h0000_00A5, "R2 input read");
        wr(ad(0), 32'h0000_00F0);
        chk("R2 set", pin_out, 32'h0000_00F0);
        wr(ad(0), 32'h0000_0003);
        chk("R2 set keeps others", pin_out, 32'h0000_00F3);
        wr(ad(1), 32'h0000_0081);
        chk("R3 clear", pin_out, 32'h0000_0072);

        wr(ad(2), 32'h0000_FF00);
        chk("R4 dir out", pin_oe, 32'h0000_FF00);
        wr(ad(3), 32'h0000_0F00);
        chk("R4 dir in", pin_oe, 32'h0000_F000);
        rd(ad(3), 32'h0000_F000, "R4 read idx3");
        rd(ad(2), 32'h0000_F000, "R4 read idx2");

        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h42, 32'hFFFF_FFFF);
        rd(ad(2), 32'h0000_F000, "R13 writes ignored dir");
        rd(ad(4), 32'd0, "R13 writes ignored ien");
        rd(8'h38, 32'd0, "R13 idx14 reads zero");
        rd(8'h41, 32'd0, "R13 misaligned reads zero");

        @(negedge clk); psel = 1; penable = 1; pwrite = 1; paddr = ad(0); pwdata = 32'hFFFF_0000;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        @(negedge clk);
        chk("R14 lone access ignored", pin_out, 32'h0000_0072);

        pin_in = 32'd0; settle();
        rd(ad(1), 32'hFFFF_FFFF, "R12 status active-low level");
        chk("R5 irq off when masked", {31'd0, irq}, 32'd0);
        wr(ad(8), 32'hFFFF_FFFF);
        rd(ad(9), 32'hFFFF_FFFF, "R8 polarity read");
        rd(ad(1), 32'd0, "R7 level active-high");

        wr(ad(4), 32'h0000_0010);
        rd(ad(5), 32'h0000_0010, "R5 enable read");
        chk("R5 irq low", {31'd0, irq}, 32'd0);
        pin_in = 32'h0000_0010; settle();
        chk("R7 level irq high", {31'd0, irq}, 32'd1);
        pin_in = 32'd0; settle();
        chk("R7 level not latched", {31'd0, irq}, 32'd0);

        wr(ad(6), 32'h0000_0010);
        rd(ad(7), 32'h0000_0010, "R6 mode read");
        pin_in = 32'h0000_0010; settle();
        chk("R8 rising edge", {31'd0, irq}, 32'd1);
        pin_in = 32'd0; settle();
        chk("R8 latched", {31'd0, irq}, 32'd1);
        rd(ad(1), 32'h0000_0010, "R8 status latched");
        wr(ad(12), 32'h0000_0010);
        chk("R10 flag cleared", {31'd0, irq}, 32'd0);
        rd(ad(12), 32'd0, "R10 reads zero");

        wr(ad(9), 32'h0000_0010);
        pin_in = 32'h0000_0010; settle();
        chk("R8 falling pol ignores rise", {31'd0, irq}, 32'd0);
        pin_in = 32'd0; settle();
        chk("R8 falling edge", {31'd0, irq}, 32'd1);
        wr(ad(12), 32'h0000_0010);

        wr(ad(10), 32'h0000_0010);
        rd(ad(11), 32'h0000_0010, "R9 any-edge read");
        pin_in = 32'h0000_0010; settle();
        chk("R9 any rise", {31'd0, irq}, 32'd1);
        wr(ad(12), 32'h0000_0010);
        chk("R9 cleared", {31'd0, irq}, 32'd0);
        pin_in = 32'd0; settle();
        chk("R9 any fall", {31'd0, irq}, 32'd1);
        wr(ad(12), 32'h0000_0010);
        wr(ad(7), 32'h0000_0010);
        rd(ad(6), 32'd0, "R6 level restored");

        wr(ad(5), 32'h0000_0010);
        rd(ad(4), 32'd0, "R5 enable cleared");

        wr(ad(13), 32'd1);
        rd(ad(13), 32'd1, "R11 ctrl read");
        wr(ad(0), 32'h0000_0100);
        settle();
        rd(ad(0), 32'h0000_0172, "R11 loopback input");
        wr(ad(13), 32'd0);
        settle();
        rd(ad(0), 32'd0, "R11 normal input");

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule